// File: doc/BRIEF.md
# C-4 Row Rate-Adaptation Mapper

The block places a serial plesiochronous bit stream of about 139 Mbit/s into a container of 9 rows by 260 byte columns, one byte column at a time. Every row is built on its own as twenty blocks of thirteen bytes. The first byte of each block is a lead byte of type W, X, Y or Z. The other twelve bytes carry payload bits. Incoming bits are held in a small elastic bit buffer. Once per row, the buffer fill level decides whether the single justification-opportunity bit of that row carries data or stuff. Five control bits in the row record that choice.

The mapper handles one output bit position per clock, so one byte completes every eight clocks. That byte is presented with its row and column index. The bit source runs at roughly 93 % of the clock rate, with a valid strobe. A frame-start pulse sets the mapper to row 0, column 0. After that the counters wrap by themselves at 260 columns and 9 rows. Sticky flags report buffer overflow and underflow.

The sequencer has two states. ST_WAIT is entered at reset and emits nothing. Bits that arrive in ST_WAIT are still buffered. ST_WAIT moves to ST_MAP on a frame-start pulse. In ST_MAP a frame-start pulse sets the position back to the first bit of row 0, column 0. On every other clock the position advances by one bit.

Top module: `c4_mapper`

## Requirements
- R1: After reset, out_vld, ovf_flag and unf_flag are 0. No byte is emitted before the first frm_start, and valid input bits that arrive in that time are buffered.
- R2: Once started, out_vld is high for one clock after each eighth bit position. out_col runs 0 to 259 and then wraps to 0. At each column wrap out_row steps from 0 to 8 and then wraps to 0 with no new frm_start.
- R3: The clock edge that samples frm_start still processes the current bit slot. The following slot is bit 0 of row 0, column 0. The byte at row 0, column 0 is flagged on the eighth rising edge after the sampling edge.
- R4: The payload positions of a row are the W byte and the bytes at column offsets 1 to 12 of every block. They carry buffered bits in arrival order, with the earliest bit in bit 7 of each byte.
- R5: A lead byte sits at column 13*b of block b. W is at block 0, X at blocks 1, 5, 9, 13 and 17, and Z at block 19. Y is at every other block. A Y byte is 0x00. An X byte has the control bit C in bit 7 and zeros in bits 6 to 0, which hold five fixed stuff bits and two overhead bits.
- R6: At bit 0 of column 0 of each row, the buffer fill is taken before that clock's read or write. If the fill is below FILL_THRESH (default 64), all five C bits of the row are 1 and the S bit is a stuff 0 that consumes no buffered bit. Otherwise all C bits are 0 and S carries the next data bit.
- R7: The Z byte at column 247 carries six data bits in bits 7 to 2, the S bit in bit 1 and a fixed 0 in bit 0.
- R8: The buffer holds BUF_DEPTH bits (default 128). A valid bit that arrives while the buffer is full, in a clock that reads no bit, is dropped. It sets ovf_flag, which stays set until reset.
- R9: A payload read from an empty buffer yields a 0 bit. It sets unf_flag, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-slot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_bit | input | 1 | Serial tributary data bit |
| ser_vld | input | 1 | Qualifies ser_bit on this clock |
| frm_start | input | 1 | Sets the mapper to row 0, column 0 |
| out_byte | output | 8 | Completed container byte, first-mapped bit in bit 7 |
| out_vld | output | 1 | out_byte, out_row and out_col are valid |
| out_row | output | 4 | Row index 0..8 of out_byte |
| out_col | output | 9 | Column index 0..259 of out_byte |
| ovf_flag | output | 1 | Sticky elastic-buffer overflow |
| unf_flag | output | 1 | Sticky elastic-buffer underflow |

## Verification
The assertions check the following on every cycle:
- the zero content of Y bytes and the zero low seven bits of X bytes;
- that every C bit in a row agrees with the first one;
- that S is 0 whenever C is set, and that the last bit of Z is 0;
- the one-clock width of out_vld and the range of the indices;
- that both flags stay set once raised;
- that no byte appears before the first frame start.

Only the bench scenarios can show the rest. This covers the arrival order of payload bits and the threshold decision under slow and fast tributaries. It also covers the realignment latency after a frame start in mid-frame and the moment the buffer first overflows or underflows.

// File: rtl/c4_map_pkg.sv
package c4_map_pkg;

    // Kind of lead byte that opens a 13-byte block
    typedef enum logic [1:0] {
        LEAD_W,
        LEAD_X,
        LEAD_Y,
        LEAD_Z
    } lead_e;

    // Role of the bit slot currently being mapped
    typedef enum logic [1:0] {
        SLOT_DATA,
        SLOT_FIX,
        SLOT_CTRL,
        SLOT_JOPP
    } slot_e;

    // Row sequencer states
    typedef enum logic {
        ST_WAIT,
        ST_MAP
    } seq_state_e;

    // Lead byte of block blk in a row of nblk blocks
    function automatic lead_e lead_of(input int unsigned blk, input int unsigned nblk);
        if (blk == 0) begin
            return LEAD_W;
        end else if (blk == nblk - 1) begin
            return LEAD_Z;
        end else if ((blk % 4) == 1) begin
            return LEAD_X;
        end else begin
            return LEAD_Y;
        end
    endfunction

endpackage

// File: rtl/c4_bit_fifo.sv
module c4_bit_fifo #(
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            push_bit,
    input  logic            pop,
    output logic            pop_bit,
    output logic [CNTW-1:0] fill,
    output logic            ovf,
    output logic            unf
);

    logic            mem [DEPTH];
    logic [AW-1:0]   wptr_q;
    logic [AW-1:0]   rptr_q;
    logic [CNTW-1:0] cnt_q;
    logic            ovf_q;
    logic            unf_q;
    logic            empty;
    logic            full;
    logic            pop_ok;
    logic            push_ok;

    always_comb begin
        empty   = (cnt_q == '0);
        full    = (cnt_q == CNTW'(DEPTH));
        pop_ok  = pop && !empty;
        push_ok = push && (!full || pop_ok);
        pop_bit = empty ? 1'b0 : mem[rptr_q];
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wptr_q] <= push_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
        end else begin
            if (push_ok) begin
                wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
            end
            if (pop_ok) begin
                rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
            end
            unique case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
            if (push && !push_ok) begin
                ovf_q <= 1'b1;
            end
            if (pop && empty) begin
                unf_q <= 1'b1;
            end
        end
    end

    assign fill = cnt_q;
    assign ovf  = ovf_q;
    assign unf  = unf_q;

endmodule

// File: rtl/c4_row_seq.sv
module c4_row_seq
    import c4_map_pkg::*;
#(
    parameter int ROWS      = 9,
    parameter int BLKS      = 20,
    parameter int BLK_BYTES = 13,
    localparam int COLS = BLKS * BLK_BYTES,
    localparam int RW   = $clog2(ROWS),
    localparam int CW   = $clog2(COLS),
    localparam int BW   = $clog2(BLKS),
    localparam int YW   = $clog2(BLK_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frm_start,
    output logic          slot_act,
    output slot_e         slot_kind,
    output logic          slot_last,
    output logic          slot_rowstart,
    output logic [RW-1:0] slot_row,
    output logic [CW-1:0] slot_col
);

    seq_state_e    state_q;
    seq_state_e    state_d;
    logic [2:0]    bit_q;
    logic [YW-1:0] bib_q;
    logic [BW-1:0] blk_q;
    logic [CW-1:0] col_q;
    logic [RW-1:0] row_q;
    logic          last_col;
    lead_e         lead;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: WAIT -> MAP on frame start; MAP holds and realigns
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: if (frm_start) state_d = ST_MAP;
            ST_MAP:  state_d = ST_MAP;
        endcase
    end

    assign last_col = (col_q == CW'(COLS - 1));

    // Position counters: bit, byte in block, block, column, row
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= '0;
            bib_q <= '0;
            blk_q <= '0;
            col_q <= '0;
            row_q <= '0;
        end else if (frm_start) begin
            bit_q <= '0;
            bib_q <= '0;
            blk_q <= '0;
            col_q <= '0;
            row_q <= '0;
        end else if (state_q == ST_MAP) begin
            if (bit_q == 3'd7) begin
                bit_q <= '0;
                col_q <= last_col ? '0 : col_q + 1'b1;
                if (bib_q == YW'(BLK_BYTES - 1)) begin
                    bib_q <= '0;
                    blk_q <= (blk_q == BW'(BLKS - 1)) ? '0 : blk_q + 1'b1;
                end else begin
                    bib_q <= bib_q + 1'b1;
                end
                if (last_col) begin
                    row_q <= (row_q == RW'(ROWS - 1)) ? '0 : row_q + 1'b1;
                end
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    // Outputs: role of the current slot
    always_comb begin
        lead          = lead_of(32'(blk_q), BLKS);
        slot_act      = (state_q == ST_MAP);
        slot_last     = (bit_q == 3'd7);
        slot_rowstart = slot_act && (col_q == '0) && (bit_q == 3'd0);
        slot_row      = row_q;
        slot_col      = col_q;
        slot_kind     = SLOT_DATA;
        if (bib_q == '0) begin
            unique case (lead)
                LEAD_W: slot_kind = SLOT_DATA;
                LEAD_X: slot_kind = (bit_q == 3'd0) ? SLOT_CTRL : SLOT_FIX;
                LEAD_Y: slot_kind = SLOT_FIX;
                LEAD_Z: begin
                    if (bit_q < 3'd6) begin
                        slot_kind = SLOT_DATA;
                    end else if (bit_q == 3'd6) begin
                        slot_kind = SLOT_JOPP;
                    end else begin
                        slot_kind = SLOT_FIX;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/c4_byte_pack.sv
module c4_byte_pack #(
    parameter int RW = 4,
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          shift_bit,
    input  logic          last,
    input  logic [RW-1:0] row_in,
    input  logic [CW-1:0] col_in,
    output logic [7:0]    out_byte,
    output logic          out_vld,
    output logic [RW-1:0] out_row,
    output logic [CW-1:0] out_col
);

    logic [6:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q     <= '0;
            out_byte <= '0;
            out_vld  <= 1'b0;
            out_row  <= '0;
            out_col  <= '0;
        end else begin
            out_vld <= 1'b0;
            if (shift_en) begin
                sh_q <= {sh_q[5:0], shift_bit};
                if (last) begin
                    out_byte <= {sh_q, shift_bit};
                    out_vld  <= 1'b1;
                    out_row  <= row_in;
                    out_col  <= col_in;
                end
            end
        end
    end

endmodule

// File: rtl/c4_mapper.sv
module c4_mapper
    import c4_map_pkg::*;
#(
    parameter int ROWS        = 9,
    parameter int BLKS        = 20,
    parameter int BLK_BYTES   = 13,
    parameter int BUF_DEPTH   = 128,
    parameter int FILL_THRESH = 64,
    localparam int COLS = BLKS * BLK_BYTES,
    localparam int RW   = $clog2(ROWS),
    localparam int CW   = $clog2(COLS),
    localparam int CNTW = $clog2(BUF_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_bit,
    input  logic          ser_vld,
    input  logic          frm_start,
    output logic [7:0]    out_byte,
    output logic          out_vld,
    output logic [RW-1:0] out_row,
    output logic [CW-1:0] out_col,
    output logic          ovf_flag,
    output logic          unf_flag
);

    logic            slot_act;
    slot_e           slot_kind;
    logic            slot_last;
    logic            slot_rowstart;
    logic [RW-1:0]   slot_row;
    logic [CW-1:0]   slot_col;
    logic [CNTW-1:0] fill;
    logic            fifo_bit;
    logic            fifo_pop;
    logic            map_bit;
    logic            jc_q;
    logic            jc_d;

    c4_row_seq #(
        .ROWS     (ROWS),
        .BLKS     (BLKS),
        .BLK_BYTES(BLK_BYTES)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .frm_start    (frm_start),
        .slot_act     (slot_act),
        .slot_kind    (slot_kind),
        .slot_last    (slot_last),
        .slot_rowstart(slot_rowstart),
        .slot_row     (slot_row),
        .slot_col     (slot_col)
    );

    c4_bit_fifo #(
        .DEPTH(BUF_DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (ser_vld),
        .push_bit(ser_bit),
        .pop     (fifo_pop),
        .pop_bit (fifo_bit),
        .fill    (fill),
        .ovf     (ovf_flag),
        .unf     (unf_flag)
    );

    // Justification decision, taken once at the first slot of a row
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            jc_q <= 1'b0;
        end else begin
            jc_q <= jc_d;
        end
    end

    always_comb begin
        jc_d     = jc_q;
        if (slot_rowstart) begin
            jc_d = (fill < CNTW'(FILL_THRESH));
        end
        fifo_pop = 1'b0;
        map_bit  = 1'b0;
        unique case (slot_kind)
            SLOT_DATA: begin
                fifo_pop = slot_act;
                map_bit  = fifo_bit;
            end
            SLOT_JOPP: begin
                fifo_pop = slot_act && !jc_q;
                map_bit  = jc_q ? 1'b0 : fifo_bit;
            end
            SLOT_CTRL: map_bit = jc_q;
            SLOT_FIX:  map_bit = 1'b0;
        endcase
    end

    c4_byte_pack #(
        .RW(RW),
        .CW(CW)
    ) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (slot_act),
        .shift_bit(map_bit),
        .last     (slot_last),
        .row_in   (slot_row),
        .col_in   (slot_col),
        .out_byte (out_byte),
        .out_vld  (out_vld),
        .out_row  (out_row),
        .out_col  (out_col)
    );

endmodule

// File: rtl/c4_mapper_chk.sv
module c4_mapper_chk #(
    parameter int ROWS      = 9,
    parameter int BLKS      = 20,
    parameter int BLK_BYTES = 13
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 frm_start,
    input logic                                 out_vld,
    input logic [7:0]                           out_byte,
    input logic [$clog2(ROWS)-1:0]              out_row,
    input logic [$clog2(BLKS*BLK_BYTES)-1:0]    out_col,
    input logic                                 ovf_flag,
    input logic                                 unf_flag
);

    localparam int COLS = BLKS * BLK_BYTES;

    int unsigned o_blk;
    int unsigned o_bib;
    logic        is_x;
    logic        is_y;
    logic        is_z;
    logic        started_q;
    logic        seen_c_q;
    logic        cur_c_q;

    always_comb begin
        o_blk = 32'(out_col) / BLK_BYTES;
        o_bib = 32'(out_col) % BLK_BYTES;
        is_z  = out_vld && (o_bib == 0) && (o_blk == BLKS - 1);
        is_x  = out_vld && (o_bib == 0) && (o_blk != BLKS - 1) && ((o_blk % 4) == 1);
        is_y  = out_vld && (o_bib == 0) && (o_blk != 0) && (o_blk != BLKS - 1)
                && ((o_blk % 4) != 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            seen_c_q  <= 1'b0;
            cur_c_q   <= 1'b0;
        end else begin
            if (frm_start) begin
                started_q <= 1'b1;
            end
            if (is_x && (o_blk == 1)) begin
                seen_c_q <= 1'b1;
                cur_c_q  <= out_byte[7];
            end
        end
    end

    p_quiet_before_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !started_q |-> !out_vld);

    p_byte_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |=> !out_vld);

    p_index_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (32'(out_row) < ROWS) && (32'(out_col) < COLS));

    p_y_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        is_y |-> (out_byte == 8'h00));

    p_x_layout_r5: assert property (@(posedge clk) disable iff (!rst_n)
        is_x |-> (out_byte[6:0] == 7'h00));

    p_c_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_x && (o_blk != 1) && seen_c_q) |-> (out_byte[7] == cur_c_q));

    p_s_stuffed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_z && seen_c_q && cur_c_q) |-> (out_byte[1] == 1'b0));

    p_z_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        is_z |-> (out_byte[0] == 1'b0));

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    p_unf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        unf_flag |=> unf_flag);

endmodule

bind c4_mapper c4_mapper_chk #(
    .ROWS     (ROWS),
    .BLKS     (BLKS),
    .BLK_BYTES(BLK_BYTES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .frm_start(frm_start),
    .out_vld  (out_vld),
    .out_byte (out_byte),
    .out_row  (out_row),
    .out_col  (out_col),
    .ovf_flag (ovf_flag),
    .unf_flag (unf_flag)
);

// File: tb/sim_c4_mapper.sv
`timescale 1ns/1ps
module sim_c4_mapper;

    localparam int DEPTH  = 128;
    localparam int THRESH = 64;
    localparam int ROWBITS = 2080;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_bit = 1'b0;
    logic       ser_vld = 1'b0;
    logic       frm_start = 1'b0;
    logic [7:0] out_byte;
    logic       out_vld;
    logic [3:0] out_row;
    logic [8:0] out_col;
    logic       ovf_flag;
    logic       unf_flag;

    always #2 clk = ~clk;

    c4_mapper u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_bit  (ser_bit),
        .ser_vld  (ser_vld),
        .frm_start(frm_start),
        .out_byte (out_byte),
        .out_vld  (out_vld),
        .out_row  (out_row),
        .out_col  (out_col),
        .ovf_flag (ovf_flag),
        .unf_flag (unf_flag)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string lead_pat = "WXYYYXYYYXYYYXYYYXYZ";

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference model
    bit         mq[$];
    bit         m_run;
    int         m_bit, m_col, m_row;
    bit         m_jc, m_ovf, m_unf;
    logic [7:0] m_sh;
    bit         e_vld;
    logic [7:0] e_byte;
    int         e_row, e_col;

    always @(posedge clk) begin : ref_model
        int  fill;
        int  bib;
        bit  need;
        bit  b;
        bit  took;
        byte lt;
        if (!rst_n) begin
            mq.delete();
            m_run = 0; m_bit = 0; m_col = 0; m_row = 0;
            m_jc = 0; m_ovf = 0; m_unf = 0; m_sh = 0;
            e_vld = 0; e_byte = 0; e_row = 0; e_col = 0;
        end else begin
            fill = mq.size();
            need = 0; b = 0; took = 0;
            e_vld = 0;
            if (m_run) begin
                lt  = lead_pat[m_col / 13];
                bib = m_col % 13;
                if (m_col == 0 && m_bit == 0) m_jc = (fill < THRESH);
                if (bib != 0 || lt == "W") need = 1;
                else if (lt == "X") b = (m_bit == 0) ? m_jc : 1'b0;
                else if (lt == "Z") begin
                    if (m_bit < 6) need = 1;
                    else if (m_bit == 6) need = !m_jc;
                end
                if (need) begin
                    if (fill == 0) m_unf = 1;
                    else begin b = mq.pop_front(); took = 1; end
                end
                m_sh = {m_sh[6:0], b};
                if (m_bit == 7) begin
                    e_vld = 1; e_byte = m_sh; e_row = m_row; e_col = m_col;
                end
                m_bit++;
                if (m_bit == 8) begin
                    m_bit = 0; m_col++;
                    if (m_col == 260) begin
                        m_col = 0; m_row++;
                        if (m_row == 9) m_row = 0;
                    end
                end
            end
            if (ser_vld) begin
                if (fill < DEPTH || took) mq.push_back(ser_bit);
                else m_ovf = 1;
            end
            if (frm_start) begin
                m_run = 1; m_bit = 0; m_col = 0; m_row = 0;
            end
        end
    end

    // Per-clock comparison against the model
    bit last_c = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2", "out_vld", {31'd0, out_vld}, {31'd0, e_vld});
            if (e_vld) begin
                chk("R2", "out_row", {28'd0, out_row}, e_row);
                chk("R2", "out_col", {23'd0, out_col}, e_col);
                if ((e_col % 13) != 0 || lead_pat[e_col / 13] == "W")
                    chk("R4", "payload byte", {24'd0, out_byte}, {24'd0, e_byte});
                else if (lead_pat[e_col / 13] == "Z")
                    chk("R7", "Z byte", {24'd0, out_byte}, {24'd0, e_byte});
                else
                    chk("R5", "lead byte", {24'd0, out_byte}, {24'd0, e_byte});
            end
            chk("R8", "ovf_flag", {31'd0, ovf_flag}, {31'd0, m_ovf});
            chk("R9", "unf_flag", {31'd0, unf_flag}, {31'd0, m_unf});
            if (out_vld && out_col == 9'd13) last_c = out_byte[7];
        end
    end

    // Stimulus: evenly spread valid bits at rate/2080 per clock
    int          acc = 0;
    int          rate = 1935;
    logic [15:0] lfsr = 16'hACE1;

    task automatic step();
        @(negedge clk);
        acc += rate;
        if (acc >= ROWBITS) begin
            acc -= ROWBITS;
            ser_vld = 1'b1;
            ser_bit = lfsr[0];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end else begin
            ser_vld = 1'b0;
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic restart();
        int cnt;
        step();
        frm_start = 1'b1;
        step();
        frm_start = 1'b0;
        cnt = 1;
        while (!out_vld && cnt < 40) begin
            step();
            cnt++;
        end
        chk("R3", "negedges to first byte", cnt, 9);
        chk("R3", "first row", {28'd0, out_row}, 0);
        chk("R3", "first col", {23'd0, out_col}, 0);
    endtask

    initial begin
        int seen;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "out_vld after reset", {31'd0, out_vld}, 0);
        chk("R1", "ovf_flag after reset", {31'd0, ovf_flag}, 0);
        chk("R1", "unf_flag after reset", {31'd0, unf_flag}, 0);

        // Buffer 70 bits while waiting; nothing may be emitted
        seen = 0;
        for (int i = 0; i < 70; i++) begin
            @(negedge clk);
            ser_vld = 1'b1;
            ser_bit = lfsr[0];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (out_vld) seen++;
        end
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            ser_vld = 1'b0;
            if (out_vld) seen++;
        end
        chk("R1", "bytes before frame start", seen, 0);

        // Start, fast tributary: fill stays above threshold
        rate = 1940;
        restart();
        run(2 * ROWBITS);
        chk("R6", "C bit with fill above threshold", {31'd0, last_c}, 0);

        // Slower tributary: fill drains below threshold, crosses frame wrap
        rate = 1930;
        run(8 * ROWBITS);
        chk("R6", "C bit with fill below threshold", {31'd0, last_c}, 1);
        chk("R9", "no underflow yet", {31'd0, unf_flag}, 0);
        chk("R8", "no overflow yet", {31'd0, ovf_flag}, 0);

        // Realign in mid-frame
        run(777);
        restart();

        // Starve: underflow
        rate = 1700;
        run(2 * ROWBITS);
        chk("R9", "underflow flagged", {31'd0, unf_flag}, 1);
        chk("R8", "still no overflow", {31'd0, ovf_flag}, 0);

        // Flood: overflow
        rate = ROWBITS;
        run(3 * ROWBITS);
        chk("R8", "overflow flagged", {31'd0, ovf_flag}, 1);
        chk("R9", "underflow still set", {31'd0, unf_flag}, 1);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule